// File: doc/BRIEF.md
# Safe Position CRC-16 Checker

This block protects a safe-position record carried over an encoder link. A record is six bytes long: first a status byte, then a 40-bit position sent most significant byte first. The block takes the bytes one per clock from a byte stream that has a valid strobe and a start-of-record strobe. It computes a 16-bit CRC over the six bytes and compares that CRC with the 16-bit CRC received beside the record. When the record is complete it pulses a done strobe. In the same cycle it presents the computed CRC as a high byte and a low byte, and it raises a mismatch flag if the two CRCs differ.

The generator polynomial is x16+x15+x12+x7+x6+x4+x3+1, which is 0x90D9 in normal form. The register starts from zero. Neither the input bytes nor the result are bit-reversed, and the result is XORed with 0x00FF at the end. Each byte is folded in, MSB first, by an update that is unrolled over its eight bits, so the block accepts one byte in every clock. The link framing and the extraction of the bytes from frames are done upstream.

Top module: `sp_crc_check`

## Requirements
- R1: The CRC uses the generator 0x90D9 (normal form). Each byte is shifted in MSB first. For each bit, the feedback is the CRC MSB XOR the data bit; the CRC shifts left by one, and the polynomial is XORed in when the feedback is 1. A record of five zero bytes followed by 0x01 gives the result 0x9026.
- R2: A byte accepted with the start strobe begins a record. That byte is folded into a CRC register that starts from 0x0000, so a record of six zero bytes gives 0x00FF.
- R3: The result is the register after the sixth byte XORed with 0x00FF. `crc_hi` carries result bits 15:8 and `crc_lo` carries bits 7:0.
- R4: The bytes are folded in the order they arrive after the start strobe: the status byte, then position bytes 4, 3, 2, 1, 0. Reversing the order of the bytes in a record changes the result to the CRC of the reversed sequence.
- R5: `done` is high for exactly one cycle: the cycle after the clock edge that accepts the sixth byte of a record.
- R6: While `done` is high, `mismatch` is 1 when the result differs from the `rx_crc` value present with the sixth byte, and 0 when the two are equal.
- R7: Cycles with `in_valid` low between the bytes of a record are skipped. The record continues and gives the same result as a record sent without gaps.
- R8: A start strobe that comes while a record is incomplete abandons that record. It produces no `done` for the abandoned record, and it begins a new record from 0x0000.
- R9: Bytes with `in_valid` high and no start strobe, arriving outside a record (before the first start strobe or after a sixth byte), are ignored. They produce no `done`, and `crc_hi`, `crc_lo` and `mismatch` do not change.
- R10: After synchronous reset, `done`, `mismatch`, `crc_hi` and `crc_lo` are all 0.
- R11: `crc_hi`, `crc_lo` and `mismatch` hold their values from one `done` to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The byte on `in_byte` is presented this cycle |
| in_sor | input | 1 | Start of record: the valid byte is the status byte |
| in_byte | input | 8 | Record byte |
| rx_crc | input | 16 | Received CRC, sampled with the sixth byte |
| crc_hi | output | 8 | Computed result, bits 15:8 |
| crc_lo | output | 8 | Computed result, bits 7:0 |
| done | output | 1 | One-cycle strobe after a complete record |
| mismatch | output | 1 | The result differs from the received CRC |

## Verification
The hardest case to reach is a record abandoned partway through and then followed at once by a fresh start strobe. The CRC register then holds partial, non-zero state, and the check is that the block reloads zero instead of continuing from that state. The stimulus sends three bytes that open a record and then a complete record with its own start strobe, and it checks that the result equals the independent reference for the second record alone. Stray bytes are also driven before the first start strobe and after a sixth byte, to show that no done appears and the held outputs stay unchanged.

// File: rtl/sp_crc_pkg.sv
package sp_crc_pkg;

  // Per-cycle control from the record sequencer to the accumulator
  typedef struct packed {
    logic first;  // byte opens a record, fold from the initial value
    logic cont;   // byte continues an open record
    logic last;   // byte completes the record
  } sp_crc_ctl_t;

endpackage

// File: rtl/sp_crc_step.sv
module sp_crc_step #(
  parameter int          CRC_W  = 16,
  parameter int          DATA_W = 8,
  parameter logic [15:0] POLY   = 16'h90D9
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);

  logic [CRC_W-1:0] chain [0:DATA_W];
  logic [DATA_W-1:0] fb;

  assign chain[0] = crc_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // MSB of the data enters first
    assign fb[i]        = chain[i][CRC_W-1] ^ data_in[DATA_W-1-i];
    assign chain[i+1]   = {chain[i][CRC_W-2:0], 1'b0} ^ (fb[i] ? POLY[CRC_W-1:0] : '0);
  end

  assign crc_out = chain[DATA_W];

endmodule

// File: rtl/sp_crc_seq.sv
module sp_crc_seq
  import sp_crc_pkg::*;
#(
  parameter int REC_BYTES = 6,
  localparam int CNT_W    = $clog2(REC_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_sor,
  output sp_crc_ctl_t ctl
);

  logic [CNT_W-1:0] count_q;
  logic             open_rec;

  assign open_rec  = (count_q != '0);
  assign ctl.first = in_valid && in_sor;
  assign ctl.cont  = in_valid && !in_sor && open_rec;
  assign ctl.last  = (ctl.first && (REC_BYTES == 1)) ||
                     (ctl.cont && (count_q == CNT_W'(REC_BYTES - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (ctl.last) begin
      count_q <= '0;
    end else if (ctl.first) begin
      count_q <= CNT_W'(1);
    end else if (ctl.cont) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  // R8
  restart_count_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sor) |=> ((REC_BYTES == 1) ? (count_q == '0) : (count_q == CNT_W'(1))));

  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!open_rec && in_valid && !in_sor) |=> (count_q == '0));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_q < CNT_W'(REC_BYTES));

endmodule

// File: rtl/sp_crc_acc.sv
module sp_crc_acc
  import sp_crc_pkg::*;
#(
  parameter int          CRC_W   = 16,
  parameter int          DATA_W  = 8,
  parameter logic [15:0] POLY    = 16'h90D9,
  parameter logic [15:0] INIT    = 16'h0000,
  parameter logic [15:0] XOR_OUT = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  sp_crc_ctl_t       ctl,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CRC_W-1:0]  rx_crc,
  output logic [CRC_W-1:0]  result,
  output logic              done,
  output logic              mismatch
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_next;
  logic [CRC_W-1:0] crc_final;
  logic [CRC_W-1:0] result_q;
  logic             done_q;
  logic             mismatch_q;

  assign crc_base  = ctl.first ? INIT[CRC_W-1:0] : crc_q;
  assign crc_final = crc_next ^ XOR_OUT[CRC_W-1:0];

  sp_crc_step #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W),
    .POLY   (POLY)
  ) i_step (
    .crc_in  (crc_base),
    .data_in (data_in),
    .crc_out (crc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q      <= INIT[CRC_W-1:0];
      result_q   <= '0;
      done_q     <= 1'b0;
      mismatch_q <= 1'b0;
    end else begin
      done_q <= ctl.last;
      if (ctl.first || ctl.cont) begin
        crc_q <= crc_next;
      end
      if (ctl.last) begin
        result_q   <= crc_final;
        mismatch_q <= (crc_final != rx_crc);
      end
    end
  end

  assign result   = result_q;
  assign done     = done_q;
  assign mismatch = mismatch_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(ctl.last));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(result_q) && $stable(mismatch_q)));

endmodule

// File: rtl/sp_crc_check.sv
module sp_crc_check
  import sp_crc_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          REC_BYTES = 6,
  parameter logic [15:0] POLY      = 16'h90D9,
  parameter logic [15:0] INIT      = 16'h0000,
  parameter logic [15:0] XOR_OUT   = 16'h00FF,
  localparam int         CRC_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sor,
  input  logic [DATA_W-1:0] in_byte,
  input  logic [CRC_W-1:0]  rx_crc,
  output logic [DATA_W-1:0] crc_hi,
  output logic [DATA_W-1:0] crc_lo,
  output logic              done,
  output logic              mismatch
);

  sp_crc_ctl_t      ctl;
  logic [CRC_W-1:0] result;

  sp_crc_seq #(
    .REC_BYTES (REC_BYTES)
  ) i_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sor   (in_sor),
    .ctl      (ctl)
  );

  sp_crc_acc #(
    .CRC_W   (CRC_W),
    .DATA_W  (DATA_W),
    .POLY    (POLY),
    .INIT    (INIT),
    .XOR_OUT (XOR_OUT)
  ) i_acc (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .data_in  (in_byte),
    .rx_crc   (rx_crc),
    .result   (result),
    .done     (done),
    .mismatch (mismatch)
  );

  assign crc_hi = result[CRC_W-1:DATA_W];
  assign crc_lo = result[DATA_W-1:0];

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!done && !mismatch && (result == '0)));

endmodule

// File: tb/test_sp_crc_check.sv
module test_sp_crc_check;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sor = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [15:0] rx_crc = 16'h0000;
  logic [7:0]  crc_hi;
  logic [7:0]  crc_lo;
  logic        done;
  logic        mismatch;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  sp_crc_check i_sp_crc_check (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sor   (in_sor),
    .in_byte  (in_byte),
    .rx_crc   (rx_crc),
    .crc_hi   (crc_hi),
    .crc_lo   (crc_lo),
    .done     (done),
    .mismatch (mismatch)
  );

  localparam int NVEC = 8;
  localparam logic [47:0] REC_T [0:NVEC-1] = '{
    48'h00_0000000000, 48'h00_0000000001, 48'h5A_123456789A, 48'hFF_FFFFFFFFFF,
    48'h01_8000000000, 48'h3C_00FF00FF00, 48'hA5_DEADBEEF01, 48'h80_0000000080
  };
  localparam logic [15:0] FLIP_T [0:NVEC-1] = '{
    16'h0000, 16'h0001, 16'h0000, 16'h8000,
    16'h0000, 16'h00FF, 16'h0100, 16'h0000
  };

  function automatic logic [15:0] crc_ref(input logic [47:0] r);
    logic [15:0] c = 16'h0000;
    for (int i = 5; i >= 0; i--) begin
      logic [7:0] d = r[i*8 +: 8];
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ d[b];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h90D9 : 16'h0000);
      end
    end
    return c ^ 16'h00FF;
  endfunction

  function automatic logic [47:0] rev_bytes(input logic [47:0] r);
    logic [47:0] o;
    for (int i = 0; i < 6; i++) o[i*8 +: 8] = r[(5-i)*8 +: 8];
    return o;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sends a record; returns at the negedge where done must be high
  task automatic send_rec(input logic [47:0] r, input logic [15:0] rx, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sor   = (i == 0);
      in_byte  = r[(5-i)*8 +: 8];
      rx_crc   = rx;
      if (gap > 0 && i < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_sor   = 1'b0;
          check("R7 no done inside gapped record", {31'd0, done}, 32'd0);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sor   = 1'b0;
  endtask

  task automatic check_result(input string tag, input logic [15:0] exp, input logic exp_mm);
    check({tag, " done"}, {31'd0, done}, 32'd1);
    check({tag, " crc"}, {16'd0, crc_hi, crc_lo}, {16'd0, exp});
    check({tag, " mismatch"}, {31'd0, mismatch}, {31'd0, exp_mm});
    @(negedge clk);
    check({tag, " done single pulse R5"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 done", {31'd0, done}, 32'd0);
    check("R10 mismatch", {31'd0, mismatch}, 32'd0);
    check("R10 crc", {16'd0, crc_hi, crc_lo}, 32'd0);

    // R9 bytes before any start strobe
    for (int i = 0; i < 7; i++) begin
      in_valid = 1'b1; in_sor = 1'b0; in_byte = 8'h33;
      @(negedge clk);
      check("R9 no done before start", {31'd0, done}, 32'd0);
    end
    in_valid = 1'b0;
    check("R9 crc unchanged before start", {16'd0, crc_hi, crc_lo}, 32'd0);

    // R2, R3 anchor: all zero record
    send_rec(48'h0, 16'h00FF, 0);
    check_result("R2 R3 zero record", 16'h00FF, 1'b0);
    // R1 anchor
    send_rec(48'h000000000001, 16'h9026, 0);
    check_result("R1 single bit record", 16'h9026, 1'b0);

    // Table walk: R1 R3 R6
    for (int v = 0; v < NVEC; v++) begin
      send_rec(REC_T[v], crc_ref(REC_T[v]) ^ FLIP_T[v], 0);
      check_result("R1 R6 table", crc_ref(REC_T[v]), FLIP_T[v] != 16'h0);
    end

    // R4 byte order
    check("R4 reversed reference differs",
          {31'd0, crc_ref(48'h5A123456789A) != crc_ref(rev_bytes(48'h5A123456789A))}, 32'd1);
    send_rec(rev_bytes(48'h5A123456789A), 16'h0000, 0);
    check_result("R4 reversed order", crc_ref(rev_bytes(48'h5A123456789A)),
                 crc_ref(rev_bytes(48'h5A123456789A)) != 16'h0000);

    // R7 gaps
    send_rec(48'hA5DEADBEEF01, crc_ref(48'hA5DEADBEEF01), 2);
    check_result("R7 gapped record", crc_ref(48'hA5DEADBEEF01), 1'b0);

    // R8 abandoned record then restart
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_sor = (i == 0); in_byte = 8'hC3 + 8'(i);
      @(negedge clk);
      check("R8 no done for partial record", {31'd0, done}, 32'd0);
    end
    send_rec(48'h5A123456789A, crc_ref(48'h5A123456789A), 0);
    check_result("R8 restart from zero", crc_ref(48'h5A123456789A), 1'b0);

    // R9 stray bytes after a complete record, R11 hold
    held = {crc_hi, crc_lo};
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_sor = 1'b0; in_byte = 8'hA5; rx_crc = 16'h1234;
      @(negedge clk);
      check("R9 no done after sixth byte", {31'd0, done}, 32'd0);
    end
    in_valid = 1'b0;
    check("R9 crc unchanged by stray bytes", {16'd0, crc_hi, crc_lo}, {16'd0, held});
    check("R9 mismatch unchanged by stray bytes", {31'd0, mismatch}, 32'd0);
    send_rec(48'h01FFFFFFFF00, 16'h0000, 0);
    check_result("R6 mismatch set", crc_ref(48'h01FFFFFFFF00), 1'b1);
    held = {crc_hi, crc_lo};
    repeat (5) @(negedge clk);
    check("R11 crc held while idle", {16'd0, crc_hi, crc_lo}, {16'd0, held});
    check("R11 mismatch held while idle", {31'd0, mismatch}, 32'd1);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule